// File: doc/BRIEF.md
# Parallel ATA PIO Strobe Timing Generator

This block drives the host-side read and write strobes of a parallel ATA interface for up to two channels. Each channel serves two attached devices. The block counts cycles of the roughly 33 MHz PCI clock, so one cycle is about 30 ns. Each pair of channel and device is a unit, numbered as twice the channel plus the device, and each unit owns a 16-bit timing word in a small byte-wide configuration space. The low byte of the word times read cycles and the high byte times write cycles. Within each byte, the low nibble sets how long the strobe stays asserted and the high nibble sets the recovery gap that follows. Both fields are stored as a complement, so the value zero gives the slowest timing.

A shared control byte holds one bit per unit in bits 7:4. Each bit chooses whether the device's IORDY line is honoured at the end of the active period or ignored, as needed for DMA-style operation. A status byte reports the busy state of the posted-write buffers. While a buffer is busy, the control byte cannot be changed.

An access is requested per channel with a direction and a device bit. The channel accepts it when it is ready. It then drives the selected strobe for the active period, stretches it while an honoured IORDY is low, and holds off the next access until the recovery period has fully elapsed.

Top module: `pata_pio_timing`

## Requirements
- R1: The timing word of unit u (u = 2 × channel + device) is at byte addresses 0x44 + 2u (low byte, read timing) and 0x45 + 2u (high byte, write timing). Every written timing byte reads back unchanged. Unmapped addresses read 0.
- R2: The strobe stays low for exactly 17 − n clocks, where n is the low nibble (bits 3:0) of the selected timing byte. This gives 2 to 17 clocks.
- R3: Between two back-to-back accesses on a channel, both strobes stay high for exactly 16 − m clocks, where m is the high nibble (bits 7:4) of the first access's timing byte. acc_ready is low for as long as a strobe is low.
- R4: A read access (acc_write = 0) uses the unit's low byte and pulses only dior_n. A write access uses the high byte and pulses only diow_n. The two strobes of a channel are never low together.
- R5: After reset, all timing words and the control byte are 0, so an access lasts 17 clocks and recovers for 16 clocks.
- R6: When control bit 4 + u is 0, IORDY is sampled at the end of the active period. The strobe then stays low until IORDY is seen high, so the width is max(17 − n, W) when IORDY rises after the W-th low clock. When the bit is 1, IORDY has no effect.
- R7: Address 0x43 reads {6'b0, post_busy}. A write to the control byte at 0x42 is ignored while post_busy is non-zero and takes effect when it is zero.
- R8: The timing and IORDY setting are captured when an access is accepted. A configuration write in the acceptance cycle or later does not alter that access but applies to the next one.
- R9: The channels run independently. Accesses accepted on both channels in the same cycle each follow their own unit's timing and direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PCI clock, about 33 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration byte write enable |
| cfg_addr | input | CFG_AW | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for cfg_addr, combinational |
| post_busy | input | 2 | Busy flags of the posted-write buffers |
| acc_req | input | NUM_CHAN | Access request per channel |
| acc_write | input | NUM_CHAN | Direction per channel, 1 selects write |
| acc_dev | input | NUM_CHAN | Device select per channel |
| acc_ready | output | NUM_CHAN | Channel accepts a request at the next clock edge |
| iordy | input | NUM_CHAN | Device ready line per channel |
| dior_n | output | NUM_CHAN | Active-low read strobe per channel |
| diow_n | output | NUM_CHAN | Active-low write strobe per channel |

## Verification
A configuration write to a unit's timing word can land in the same clock edge that accepts an access for that unit. The bench provokes this by raising the request and the write enable on the same falling edge. It judges the result by measuring that the strobe width follows the old encoding and that the following access follows the new one. Simultaneous acceptance on both channels is provoked the same way and judged by each channel's own width and strobe line. The bench also sweeps every nibble value for active and recovery times on all four units in both directions.

// File: rtl/pata_pio_pkg.sv
package pata_pio_pkg;

   localparam int CNT_W  = 5;
   localparam int NIB_W  = 4;
   localparam int BYTE_W = 8;
   localparam int WORD_W = 2 * BYTE_W;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ACT,
      ST_HOLD,
      ST_REC
   } chan_state_e;

   typedef struct packed {
      logic [NIB_W-1:0] rec_nib;
      logic [NIB_W-1:0] act_nib;
   } tbyte_t;

   // counter preset = clocks - 1, active clocks = 17 - nib
   function automatic logic [CNT_W-1:0] act_preset(input logic [NIB_W-1:0] nib);
      return CNT_W'(16) - CNT_W'(nib);
   endfunction

   // counter preset = clocks - 1, recovery clocks = 16 - nib
   function automatic logic [CNT_W-1:0] rec_preset(input logic [NIB_W-1:0] nib);
      return CNT_W'(15) - CNT_W'(nib);
   endfunction

endpackage

// File: rtl/pata_pio_cfg.sv
module pata_pio_cfg
   import pata_pio_pkg::*;
#(
   parameter int NUM_UNITS   = 4,
   parameter int AW          = 8,
   parameter int BUSY_W      = 2,
   parameter int TIMING_BASE = 'h44,
   parameter int CTRL_ADDR   = 'h42,
   parameter int STAT_ADDR   = 'h43
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              we,
   input  logic [AW-1:0]                     addr,
   input  logic [BYTE_W-1:0]                 wdata,
   input  logic [BUSY_W-1:0]                 busy,
   output logic [BYTE_W-1:0]                 rdata,
   output logic [NUM_UNITS-1:0][WORD_W-1:0]  timing,
   output logic [BYTE_W-1:0]                 ctrl
);

   localparam int NUM_BYTES = 2 * NUM_UNITS;

   if (BUSY_W > BYTE_W) begin : g_bad_busy
      $error("BUSY_W must fit in one status byte");
   end
   if (TIMING_BASE + NUM_BYTES > (1 << AW)) begin : g_bad_map
      $error("timing words do not fit in the address space");
   end

   logic [NUM_UNITS-1:0][WORD_W-1:0] timing_q;
   logic [BYTE_W-1:0]                ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         timing_q <= '0;
         ctrl_q   <= '0;
      end else if (we) begin
         for (int i = 0; i < NUM_BYTES; i++) begin
            if (addr == AW'(TIMING_BASE + i))
               timing_q[i/2][BYTE_W*(i%2) +: BYTE_W] <= wdata;
         end
         if (addr == AW'(CTRL_ADDR) && busy == '0)
            ctrl_q <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == AW'(CTRL_ADDR)) rdata = ctrl_q;
      if (addr == AW'(STAT_ADDR)) rdata = BYTE_W'(busy);
      for (int i = 0; i < NUM_BYTES; i++) begin
         if (addr == AW'(TIMING_BASE + i))
            rdata = timing_q[i/2][BYTE_W*(i%2) +: BYTE_W];
      end
   end

   assign timing = timing_q;
   assign ctrl   = ctrl_q;

endmodule

// File: rtl/pata_pio_chan.sv
module pata_pio_chan
   import pata_pio_pkg::*;
#(
   parameter int DEVS  = 2,
   localparam int DEV_W = (DEVS > 1) ? $clog2(DEVS) : 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         req,
   input  logic                         wr,
   input  logic [DEV_W-1:0]             dev,
   input  logic                         iordy,
   input  logic [DEVS-1:0][WORD_W-1:0]  timing,
   input  logic [DEVS-1:0]              ign_rdy,
   output logic                         ready,
   output logic                         rd_n,
   output logic                         wr_n
);

   chan_state_e      state_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] rec_q;
   logic             is_wr_q;
   logic             use_rdy_q;
   tbyte_t           sel;

   always_comb begin
      if (wr) sel = tbyte_t'(timing[dev][WORD_W-1:BYTE_W]);
      else    sel = tbyte_t'(timing[dev][BYTE_W-1:0]);
   end

   assign ready = (state_q == ST_IDLE) || (state_q == ST_REC && cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         cnt_q     <= '0;
         rec_q     <= '0;
         is_wr_q   <= 1'b0;
         use_rdy_q <= 1'b0;
      end else if (ready && req) begin
         state_q   <= ST_ACT;
         cnt_q     <= act_preset(sel.act_nib);
         rec_q     <= rec_preset(sel.rec_nib);
         is_wr_q   <= wr;
         use_rdy_q <= !ign_rdy[dev];
      end else begin
         unique case (state_q)
            ST_ACT: begin
               if (cnt_q != '0) begin
                  cnt_q <= cnt_q - 1'b1;
               end else if (use_rdy_q && !iordy) begin
                  state_q <= ST_HOLD;
               end else begin
                  state_q <= ST_REC;
                  cnt_q   <= rec_q;
               end
            end
            ST_HOLD: begin
               if (iordy) begin
                  state_q <= ST_REC;
                  cnt_q   <= rec_q;
               end
            end
            ST_REC: begin
               if (cnt_q == '0) state_q <= ST_IDLE;
               else             cnt_q   <= cnt_q - 1'b1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   logic strobe_on;
   assign strobe_on = (state_q == ST_ACT) || (state_q == ST_HOLD);
   assign rd_n = !(strobe_on && !is_wr_q);
   assign wr_n = !(strobe_on && is_wr_q);

endmodule

// File: rtl/pata_pio_timing.sv
module pata_pio_timing
   import pata_pio_pkg::*;
#(
   parameter int NUM_CHAN    = 2,
   parameter int CFG_AW      = 8,
   parameter int TIMING_BASE = 'h44,
   parameter int CTRL_ADDR   = 'h42,
   parameter int STAT_ADDR   = 'h43
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [CFG_AW-1:0]    cfg_addr,
   input  logic [7:0]           cfg_wdata,
   output logic [7:0]           cfg_rdata,
   input  logic [1:0]           post_busy,
   input  logic [NUM_CHAN-1:0]  acc_req,
   input  logic [NUM_CHAN-1:0]  acc_write,
   input  logic [NUM_CHAN-1:0]  acc_dev,
   output logic [NUM_CHAN-1:0]  acc_ready,
   input  logic [NUM_CHAN-1:0]  iordy,
   output logic [NUM_CHAN-1:0]  dior_n,
   output logic [NUM_CHAN-1:0]  diow_n
);

   localparam int DEVS      = 2;
   localparam int NUM_UNITS = NUM_CHAN * DEVS;
   localparam int IGN_LSB   = 4;

   if (NUM_CHAN < 1 || NUM_CHAN > 2) begin : g_bad_chan
      $error("NUM_CHAN must be 1 or 2: the control byte holds four unit bits");
   end

   logic [NUM_UNITS-1:0][WORD_W-1:0] timing;
   logic [BYTE_W-1:0]                ctrl_byte;

   pata_pio_cfg #(
      .NUM_UNITS   (NUM_UNITS),
      .AW          (CFG_AW),
      .BUSY_W      (2),
      .TIMING_BASE (TIMING_BASE),
      .CTRL_ADDR   (CTRL_ADDR),
      .STAT_ADDR   (STAT_ADDR)
   ) u_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (cfg_we),
      .addr   (cfg_addr),
      .wdata  (cfg_wdata),
      .busy   (post_busy),
      .rdata  (cfg_rdata),
      .timing (timing),
      .ctrl   (ctrl_byte)
   );

   for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
      pata_pio_chan #(.DEVS(DEVS)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .req     (acc_req[c]),
         .wr      (acc_write[c]),
         .dev     (acc_dev[c]),
         .iordy   (iordy[c]),
         .timing  (timing[DEVS*c +: DEVS]),
         .ign_rdy (ctrl_byte[IGN_LSB + DEVS*c +: DEVS]),
         .ready   (acc_ready[c]),
         .rd_n    (dior_n[c]),
         .wr_n    (diow_n[c])
      );
   end

endmodule

// File: rtl/pata_pio_timing_chk.sv
module pata_pio_timing_chk #(
   parameter int NUM_CHAN  = 2,
   parameter int CFG_AW    = 8,
   parameter int CTRL_ADDR = 'h42,
   parameter int STAT_ADDR = 'h43
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cfg_we,
   input logic [CFG_AW-1:0]   cfg_addr,
   input logic [7:0]          cfg_rdata,
   input logic [1:0]          post_busy,
   input logic [NUM_CHAN-1:0] acc_ready,
   input logic [NUM_CHAN-1:0] dior_n,
   input logic [NUM_CHAN-1:0] diow_n,
   input logic [7:0]          ctrl_byte
);

   for (genvar c = 0; c < NUM_CHAN; c++) begin : g_ch
      p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0({!dior_n[c], !diow_n[c]}));

      p_min_active_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(dior_n[c]) |=> !dior_n[c]);

      p_min_active_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(diow_n[c]) |=> !diow_n[c]);

      p_recover_after_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(dior_n[c]) |-> diow_n[c]);

      p_recover_after_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(diow_n[c]) |-> dior_n[c]);

      p_busy_while_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (!dior_n[c] || !diow_n[c]) |-> !acc_ready[c]);
   end

   p_ctrl_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == CFG_AW'(CTRL_ADDR) && post_busy != 2'b00) |=> $stable(ctrl_byte));

   p_status_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_addr == CFG_AW'(STAT_ADDR)) |-> (cfg_rdata == {6'b0, post_busy}));

endmodule

bind pata_pio_timing pata_pio_timing_chk #(
   .NUM_CHAN  (NUM_CHAN),
   .CFG_AW    (CFG_AW),
   .CTRL_ADDR (CTRL_ADDR),
   .STAT_ADDR (STAT_ADDR)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .cfg_addr  (cfg_addr),
   .cfg_rdata (cfg_rdata),
   .post_busy (post_busy),
   .acc_ready (acc_ready),
   .dior_n    (dior_n),
   .diow_n    (diow_n),
   .ctrl_byte (ctrl_byte)
);

// File: tb/pata_pio_timing_bench.sv
module pata_pio_timing_bench;

   localparam int CLK_PERIOD = 30;
   localparam int NC = 2;

   logic          clk;
   logic          rst_n;
   logic          cfg_we;
   logic [7:0]    cfg_addr;
   logic [7:0]    cfg_wdata;
   logic [7:0]    cfg_rdata;
   logic [1:0]    post_busy;
   logic [NC-1:0] acc_req, acc_write, acc_dev, acc_ready, iordy, dior_n, diow_n;

   pata_pio_timing u_pata_pio_timing (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .post_busy(post_busy),
      .acc_req(acc_req), .acc_write(acc_write), .acc_dev(acc_dev),
      .acc_ready(acc_ready), .iordy(iordy), .dior_n(dior_n), .diow_n(diow_n)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int errors = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // strobe monitor, sampled on the falling edge
   int width[NC], gap[NC], lo[NC], hi[NC], strobes[NC];
   bit prev[NC], last_wr[NC];
   initial for (int c = 0; c < NC; c++) begin
      width[c] = 0; gap[c] = 0; lo[c] = 0; hi[c] = 0; strobes[c] = 0;
      prev[c] = 0; last_wr[c] = 0;
   end

   always @(negedge clk) begin
      for (int c = 0; c < NC; c++) begin
         if (!dior_n[c] || !diow_n[c]) begin
            if (!prev[c]) begin
               gap[c] = hi[c];
               lo[c] = 1;
               last_wr[c] = !diow_n[c];
            end else lo[c]++;
            prev[c] = 1;
         end else begin
            if (prev[c]) begin
               width[c] = lo[c];
               strobes[c]++;
               hi[c] = 1;
            end else hi[c]++;
            prev[c] = 0;
         end
      end
   end

   task automatic cfg_write(input int a, input int d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 8'(a); cfg_wdata = 8'(d);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic cfg_read(input int a, output int v);
      @(negedge clk);
      cfg_addr = 8'(a);
      #1 v = int'(cfg_rdata);
   endtask

   task automatic wait_idle(input int c);
      while (!acc_ready[c]) @(negedge clk);
   endtask

   task automatic run_pair(input int c, input int d, input int w);
      int n = 0;
      int s0 = strobes[c];
      @(negedge clk);
      acc_req[c] = 1'b1; acc_write[c] = w[0]; acc_dev[c] = d[0];
      forever begin
         if (acc_ready[c]) n++;
         if (n == 2) break;
         @(negedge clk);
      end
      @(negedge clk);
      acc_req[c] = 1'b0;
      while (strobes[c] < s0 + 2) @(negedge clk);
      wait_idle(c);
   endtask

   task automatic run_single(input int c, input int d, input int w);
      int s0 = strobes[c];
      @(negedge clk);
      acc_req[c] = 1'b1; acc_write[c] = w[0]; acc_dev[c] = d[0];
      while (!acc_ready[c]) @(negedge clk);
      @(negedge clk);
      acc_req[c] = 1'b0;
      while (strobes[c] <= s0) @(negedge clk);
      wait_idle(c);
   endtask

   // read access with IORDY low, raised after the w-th low sample
   task automatic iordy_access(input int c, input int d, input int w, output int got);
      int cnt = 0;
      iordy[c] = 1'b0;
      @(negedge clk);
      acc_req[c] = 1'b1; acc_write[c] = 1'b0; acc_dev[c] = d[0];
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         acc_req[c] = 1'b0;
         if (!dior_n[c]) cnt++;
         else if (cnt > 0) break;
         if (cnt == w) iordy[c] = 1'b1;
      end
      got = cnt;
      iordy[c] = 1'b1;
      wait_idle(c);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int v, got, s0, s1;
      rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; post_busy = '0;
      acc_req = '0; acc_write = '0; acc_dev = '0; iordy = '1;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R5: reset state of all registers and the slowest timing
      for (int a = 'h42; a < 'h4C; a++) begin
         cfg_read(a, v);
         chk(v == 0, $sformatf("R5 reset value addr 0x%0h", a), v, 0);
      end
      run_pair(0, 0, 0);
      chk(width[0] == 17, "R5 reset active width", width[0], 17);
      chk(gap[0] == 16, "R5 reset recovery gap", gap[0], 16);

      // R1: byte map readback
      for (int i = 0; i < 8; i++) cfg_write('h44 + i, (i * 37 + 5) & 255);
      for (int i = 0; i < 8; i++) begin
         cfg_read('h44 + i, v);
         chk(v == ((i * 37 + 5) & 255), $sformatf("R1 readback addr 0x%0h", 'h44 + i),
             v, (i * 37 + 5) & 255);
      end
      cfg_read('h4C, v);
      chk(v == 0, "R1 unmapped address reads zero", v, 0);

      // R2 R3 R4: sweep all nibbles on all units and both directions
      for (int u = 0; u < 4; u++) begin
         for (int w = 0; w < 2; w++) begin
            for (int k = 0; k < 16; k++) begin
               int an = k;
               int rn = (k * 7 + 3) % 16;
               int b  = rn * 16 + an;
               cfg_write('h44 + 2*u + w, b);
               cfg_write('h44 + 2*u + (1 - w), (~b) & 255);
               run_pair(u / 2, u % 2, w);
               chk(width[u/2] == 17 - an, $sformatf("R2 active u%0d w%0d n%0d", u, w, an),
                   width[u/2], 17 - an);
               chk(gap[u/2] == 16 - rn, $sformatf("R3 recovery u%0d w%0d m%0d", u, w, rn),
                   gap[u/2], 16 - rn);
               chk(int'(last_wr[u/2]) == w, $sformatf("R4 strobe line u%0d", u),
                   int'(last_wr[u/2]), w);
            end
         end
      end

      // R6: IORDY stretching on unit 3, active 4 clocks
      cfg_write('h4A, 'hED);
      cfg_write('h42, 'h00);
      iordy_access(1, 1, 9, got);
      chk(got == 9, "R6 stretched by late IORDY", got, 9);
      iordy_access(1, 1, 2, got);
      chk(got == 4, "R6 early IORDY no stretch", got, 4);
      iordy_access(1, 1, 4, got);
      chk(got == 4, "R6 IORDY at end of active", got, 4);
      iordy_access(1, 1, 5, got);
      chk(got == 5, "R6 IORDY one clock late", got, 5);
      cfg_write('h42, 'h80);
      iordy_access(1, 1, 1000, got);
      chk(got == 4, "R6 IORDY ignored when enable bit set", got, 4);

      // R7: status byte and control lock
      post_busy = 2'b01;
      cfg_read('h43, v);
      chk(v == 1, "R7 status busy bit0", v, 1);
      cfg_write('h42, 'hF0);
      cfg_read('h42, v);
      chk(v == 'h80, "R7 control write ignored busy0", v, 'h80);
      post_busy = 2'b10;
      cfg_read('h43, v);
      chk(v == 2, "R7 status busy bit1", v, 2);
      cfg_write('h42, 'h0F);
      cfg_read('h42, v);
      chk(v == 'h80, "R7 control write ignored busy1", v, 'h80);
      post_busy = 2'b00;
      cfg_write('h42, 'h00);
      cfg_read('h42, v);
      chk(v == 0, "R7 control write accepted when idle", v, 0);

      // R8: timing write in the acceptance cycle
      cfg_write('h44, 'h0E);
      s0 = strobes[0];
      @(negedge clk);
      acc_req[0] = 1'b1; acc_write[0] = 1'b0; acc_dev[0] = 1'b0;
      cfg_we = 1'b1; cfg_addr = 8'h44; cfg_wdata = 8'h00;
      @(negedge clk);
      acc_req[0] = 1'b0; cfg_we = 1'b0;
      while (strobes[0] <= s0) @(negedge clk);
      chk(width[0] == 3, "R8 access keeps captured timing", width[0], 3);
      wait_idle(0);
      run_single(0, 0, 0);
      chk(width[0] == 17, "R8 next access uses new timing", width[0], 17);

      // R9: both channels accepted together
      cfg_write('h46, 'h0C);
      cfg_write('h49, 'h08);
      s0 = strobes[0]; s1 = strobes[1];
      @(negedge clk);
      acc_req = 2'b11; acc_write = 2'b10; acc_dev = 2'b01;
      @(negedge clk);
      acc_req = 2'b00;
      while (strobes[0] <= s0 || strobes[1] <= s1) @(negedge clk);
      chk(width[0] == 5, "R9 channel 0 width", width[0], 5);
      chk(width[1] == 9, "R9 channel 1 width", width[1], 9);
      chk(last_wr[0] == 0, "R9 channel 0 read strobe", int'(last_wr[0]), 0);
      chk(last_wr[1] == 1, "R9 channel 1 write strobe", int'(last_wr[1]), 1);
      wait_idle(0);
      wait_idle(1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule